// File: doc/BRIEF.md
# I2C Slave Register Bank with Auto-Incrementing Pointer

This block is a two-wire serial slave that fronts a small bank of 8-bit control registers. It samples the clock and data lines on the system clock, recognises START, repeated START and STOP conditions, and responds only to its configured 7-bit device address. A write transfer loads a register pointer from the first byte after the address and stores every later byte at that pointer. A read transfer shifts out the register at the pointer, most significant bit first.

The pointer is shared between reads and writes and lives across transfers. It steps by one after every data byte in either direction and wraps to register 0 after the last register. Three access patterns follow from this. A burst write fills consecutive registers. A random read sets the pointer with a write and then reads after a repeated START. An address-only read resumes one past the register touched last. A registered side port lets the surrounding logic read any register in parallel.

Top module: `i2c_autoinc_slave`

## Requirements
- R1: After reset the data line is released (`sda_pull` low), the pointer is 0 and every register holds 0x00.
- R2: An address byte whose upper 7 bits differ from `DEV_ADDR` gets no acknowledge. The slave then keeps SDA released and ignores every byte until the next START or STOP. Registers and pointer are left unchanged.
- R3: In a write transfer (bit 0 of the address byte = 0) the first following byte loads the pointer (its low AW bits). Each later byte is stored at the pointer, and the slave acknowledges every byte by pulling SDA low in the ninth clock.
- R4: After every stored byte the pointer advances by one, so consecutive bytes of one transfer land in consecutive registers.
- R5: The pointer advances from register NUM_REGS-1 to register 0, in both writes and reads.
- R6: In a read transfer (bit 0 of the address byte = 1) the slave acknowledges the address and then drives the register at the pointer, MSB first. This includes a read placed after a pointer-only write and a repeated START.
- R7: When the master acknowledges a read byte (SDA low in the ninth clock), the next register is sent in the following byte.
- R8: The slave leaves SDA released during the master's acknowledge clock. After a not-acknowledge it sends nothing more until the next START.
- R9: The pointer advances after every read byte, whether it is acknowledged or not, and it is kept across STOP. An address-only read therefore returns the register after the one accessed last.
- R10: SDA is driven only as a pull-low enable, and it changes only while SCL is low.
- R11: `host_data` shows the register selected by `host_addr` one clock after that address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull | output | 1 | Open-drain enable; 1 pulls SDA low |
| host_addr | input | AW | Register select for the parallel read port |
| host_data | output | 8 | Registered contents of the selected register |

## Verification
The bench writes a short burst starting mid-bank and a second burst that crosses the top of the bank. Comparing them shows whether the pointer steps by one and whether it wraps rather than stalling or overrunning. Reads come in three forms: a random read after a repeated START, a burst read that crosses the wrap point, and an address-only read after STOP. Together these separate a pointer that advances on every byte from one that advances only on acknowledged bytes or is cleared at STOP. A foreign address followed by 0x00 and 0xFF bytes shows whether the slave stays silent and leaves both the bank and the pointer untouched.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_RD_LOAD,
    ST_IGNORE
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh   <= {sda_sh[STAGES-2:0], sda_i};
      scl_prev <= scl_sh[STAGES-1];
      sda_prev <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
  parameter int NREGS = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] ra_addr,
  output logic [7:0]    ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [7:0]    rb_data
);
  logic [7:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= 8'h00;
      rb_data <= 8'h00;
    end else begin
      if (wr_en) mem[wr_addr] <= wr_data;
      rb_data <= mem[rb_addr];
    end
  end

  assign ra_data = mem[ra_addr];
endmodule

// File: rtl/i2c_autoinc_slave.sv
module i2c_autoinc_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull,
  input  logic [AW-1:0] host_addr,
  output logic [7:0]    host_data
);
  import i2cs_pkg::*;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_state_e   state;
  logic [2:0]    bitcnt;
  logic [7:0]    shreg, txbyte, rx_byte, ra_data;
  logic [AW-1:0] ptr, ptr_nxt, ra_addr;
  logic          rw_q, wr_en, byte_done;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(NUM_REGS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rx_byte   = {shreg[6:0], sda_s};
  assign ptr_nxt   = step_ptr(ptr);
  assign byte_done = scl_rise && (bitcnt == 3'd7) && !start_det && !stop_det;
  assign wr_en     = (state == ST_WR) && byte_done;
  assign ra_addr   = (state == ST_RD_ACK) ? ptr_nxt : ptr;

  i2cs_regbank #(.NREGS(NUM_REGS), .AW(AW)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(ptr), .wr_data(rx_byte),
    .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_addr(host_addr), .rb_data(host_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txbyte   <= '0;
      ptr      <= '0;
      rw_q     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      state    <= ST_DEV;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_PTR, ST_WR: begin
          if (scl_rise) begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              case (state)
                ST_DEV: begin
                  if (rx_byte[7:1] == DEV_ADDR) begin
                    rw_q   <= rx_byte[0];
                    txbyte <= ra_data;
                    state  <= ST_DEV_ACK;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
                ST_PTR: begin
                  ptr   <= rx_byte[AW-1:0];
                  state <= ST_PTR_ACK;
                end
                default: begin
                  ptr   <= ptr_nxt;
                  state <= ST_WR_ACK;
                end
              endcase
            end
          end
        end
        ST_DEV_ACK, ST_PTR_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            if (!sda_pull) begin
              sda_pull <= 1'b1;
            end else begin
              bitcnt <= '0;
              if (state == ST_DEV_ACK && rw_q) begin
                sda_pull <= ~txbyte[7];
                state    <= ST_RD;
              end else begin
                sda_pull <= 1'b0;
                state    <= (state == ST_DEV_ACK) ? ST_PTR : ST_WR;
              end
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) state <= ST_RD_ACK;
          end else if (scl_fall && bitcnt != 3'd0) begin
            sda_pull <= ~txbyte[3'd7 - bitcnt];
          end
        end
        ST_RD_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
          end else if (scl_rise) begin
            ptr    <= ptr_nxt;
            txbyte <= ra_data;
            state  <= sda_s ? ST_IGNORE : ST_RD_LOAD;
          end
        end
        ST_RD_LOAD: begin
          if (scl_fall) begin
            sda_pull <= ~txbyte[7];
            bitcnt   <= '0;
            state    <= ST_RD;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_autoinc_slave_chk.sv
module i2c_autoinc_slave_chk #(
  parameter int NUM_REGS = 16,
  parameter int AW       = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_i,
  input logic                  sda_pull,
  input logic [AW-1:0]         ptr,
  input i2cs_pkg::i2cs_state_e state
);
  import i2cs_pkg::*;

  function automatic logic [AW-1:0] after(input logic [AW-1:0] p);
    return (p == AW'(NUM_REGS - 1)) ? '0 : p + 1'b1;
  endfunction

  // R1: bus released when reset is withdrawn
  a_r1_release_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !sda_pull);

  // R10: pull-low enable toggles only while SCL is low
  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> !scl_i);

  // R2: silent while the transfer is not addressed to this slave
  a_r2_ignore_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_pull);

  // R8: slave drives only during its own ack or read-data bits
  a_r8_drive_phase: assert property (@(posedge clk) disable iff (rst)
    sda_pull |-> (state == ST_DEV_ACK || state == ST_PTR_ACK ||
                  state == ST_WR_ACK || state == ST_RD || state == ST_RD_ACK));

  // R4 / R5: pointer moves by one with wrap unless it was loaded
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ptr) && $past(state) != ST_PTR) |-> ptr == after($past(ptr)));
endmodule

bind i2c_autoinc_slave i2c_autoinc_slave_chk #(.NUM_REGS(NUM_REGS), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_pull(sda_pull), .ptr(ptr), .state(state)
);

// File: tb/i2c_autoinc_slave_bench.sv
module i2c_autoinc_slave_bench;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int NREG = 16;
  localparam int AW   = 4;
  localparam int QTR  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_pull = 1'b0;
  logic sda_pull;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_data;
  logic sda_line;

  always #10 clk = ~clk;
  assign sda_line = ~(m_pull | sda_pull);

  i2c_autoinc_slave #(.DEV_ADDR(DEV), .NUM_REGS(NREG)) u_i2c_autoinc_slave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull(sda_pull), .host_addr(host_addr), .host_data(host_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [NREG];
  logic [AW-1:0] mptr = '0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] got_b;
  event got_ev;
  logic ack;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always begin
    @(got_ev);
    if (exp_q.size() == 0) chk(0, "scoreboard underrun", {24'd0, got_b}, 0);
    else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(got_b === e, t, {24'd0, got_b}, {24'd0, e});
    end
  end

  task automatic q(); repeat (QTR) @(negedge clk); endtask

  task automatic bit_xfer(input logic b, output logic r);
    m_pull = ~b; q();
    m_scl = 1'b1; q();
    r = sda_line; q();
    m_scl = 1'b0; q();
  endtask

  task automatic bus_start();
    m_pull = 1'b0; q();
    m_scl = 1'b1; q();
    m_pull = 1'b1; q();
    m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_pull = 1'b1; q();
    m_scl = 1'b1; q();
    m_pull = 1'b0; q(); q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
    bit_xfer(1'b1, r);
    acked = ~r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 0; i < 8; i++) begin
      bit_xfer(1'b1, r);
      b = {b[6:0], r};
    end
    bit_xfer(~give_ack, r);
    if (!give_ack) chk(r === 1'b1, "R8 line released on nack", {31'd0, r}, 1);
  endtask

  task automatic read_expect(input logic give_ack, input string tag);
    logic [7:0] b;
    exp_q.push_back(model[mptr]);
    tag_q.push_back(tag);
    mptr = (mptr == AW'(NREG - 1)) ? '0 : mptr + 1'b1;
    recv_byte(give_ack, b);
    got_b = b;
    ->got_ev;
    @(negedge clk);
  endtask

  task automatic write_burst(input logic [7:0] p, input logic [7:0] d [], input string tag);
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, {tag, " addr ack"}, {31'd0, ack}, 1);
    send_byte(p, ack);           chk(ack, "R3 pointer ack", {31'd0, ack}, 1);
    mptr = p[AW-1:0];
    foreach (d[i]) begin
      send_byte(d[i], ack);      chk(ack, "R3 data ack", {31'd0, ack}, 1);
      model[mptr] = d[i];
      mptr = (mptr == AW'(NREG - 1)) ? '0 : mptr + 1'b1;
    end
    bus_stop();
  endtask

  task automatic port_check(input logic [AW-1:0] a, input string tag);
    host_addr = a;
    @(negedge clk); @(negedge clk);
    chk(host_data === model[a], tag, {24'd0, host_data}, {24'd0, model[a]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    foreach (model[i]) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    chk(sda_pull === 1'b0, "R1 sda released after reset", {31'd0, sda_pull}, 0);
    port_check(4'd3, "R1 R11 register zero after reset");

    // R1 R9: address-only read straight after reset starts at register 0
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R6 read addr ack", {31'd0, ack}, 1);
    read_expect(1'b0, "R1 R9 current read after reset");
    bus_stop();

    // R3 R4: burst write from register 3
    write_burst(8'h03, '{8'hA1, 8'hB2, 8'hC3, 8'hD4}, "R3");
    port_check(4'd4, "R4 R11 burst write landed");
    port_check(4'd6, "R4 last burst byte");

    // R5: write crossing the top of the bank
    write_burst(8'h0E, '{8'h11, 8'h22, 8'h33, 8'h44}, "R5");
    port_check(4'd0, "R5 wrapped write reg0");
    port_check(4'd1, "R5 wrapped write reg1");
    port_check(4'd15, "R5 top register");

    // R6 R7: random read with repeated START
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R6 addr ack", {31'd0, ack}, 1);
    send_byte(8'h03, ack);       chk(ack, "R6 pointer ack", {31'd0, ack}, 1);
    mptr = 4'd3;
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R6 read addr ack", {31'd0, ack}, 1);
    read_expect(1'b1, "R6 random read first byte");
    read_expect(1'b1, "R7 burst read second byte");
    read_expect(1'b0, "R7 burst read third byte");
    chk(sda_pull === 1'b0, "R8 no drive after nack", {31'd0, sda_pull}, 0);
    bus_stop();

    // R9: address-only read resumes after last accessed register
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R9 addr ack", {31'd0, ack}, 1);
    read_expect(1'b0, "R9 current address read");
    bus_stop();

    // R5 R7: burst read across the wrap point
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h0E, ack);
    mptr = 4'd14;
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R7 addr ack", {31'd0, ack}, 1);
    read_expect(1'b1, "R7 read reg14");
    read_expect(1'b1, "R7 read reg15");
    read_expect(1'b1, "R5 read wraps to reg0");
    read_expect(1'b1, "R5 read reg1");
    read_expect(1'b0, "R7 read reg2");
    bus_stop();

    // R2: foreign address is ignored
    bus_start();
    send_byte({7'h36, 1'b0}, ack); chk(!ack, "R2 foreign write addr not acked", {31'd0, ack}, 0);
    send_byte(8'h00, ack);         chk(!ack, "R2 ignored byte not acked", {31'd0, ack}, 0);
    send_byte(8'hFF, ack);         chk(!ack, "R2 ignored byte not acked", {31'd0, ack}, 0);
    bus_stop();
    port_check(4'd0, "R2 reg0 untouched");
    bus_start();
    send_byte({7'h36, 1'b1}, ack); chk(!ack, "R2 foreign read addr not acked", {31'd0, ack}, 0);
    recv_byte(1'b0, b);            chk(b === 8'hFF, "R2 slave silent on foreign read", {24'd0, b}, 8'hFF);
    bus_stop();

    // R2 R9: pointer unaffected by the foreign traffic
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R9 addr ack", {31'd0, ack}, 1);
    read_expect(1'b0, "R2 R9 pointer kept");
    bus_stop();

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule